// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that lets a host read and write a small bank of 8-bit configuration registers over a two-wire SMBus-compatible link. The SCL and SDA lines are first brought into a fast system clock domain with two-flop synchronizers. START and STOP conditions are recognised as SDA edges that occur while SCL is high. The slave pulls SDA low through an open-drain enable, `sda_oe`. It never drives the line high.

Every transaction begins with the device address and a write, followed by a command code. When bit 7 of the command is set, the transfer is a single-byte access at the register offset held in bits 6:0. When bit 7 is clear, the transfer is a counted block access that starts at register 0.
- A block write carries a count byte ahead of its data.
- A block read, entered through a repeated START and the read address, returns the number of registers first and then the register contents in rising order.

The whole register bank is presented in parallel on `cfg_o` for use by the rest of the chip. Bit 7 of register 0 is a status bit that hardware loads from `fsel_i` on every clock.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte of D2h (write) or D3h (read). It NACKs any other address byte and then leaves SDA released until the next START.
- R2: A command byte with bit 7 = 1, followed by one data byte, writes that byte into the register whose offset is command bits 6:0. Register contents change only on an SCL falling edge.
- R3: A byte read returns the register at the last commanded offset, MSB first. The sequence is: D2h, the command, a repeated START, then D3h.
- R4: A command byte of 00h opens a block write. The next byte is the count, which is ACKed and otherwise ignored. The data bytes that follow go to registers 0, 1, 2 and so on.
- R5: A block read returns the value NREG (8 by default) first, then the registers from 0 upward. The sequence is: D2h, 00h, a repeated START, then D3h.
- R6: After reset, register 1 is 85h and register 2 is FFh. Every other register bit is 00, except register 0 bit 7.
- R7: Register 0 bit 7 equals `fsel_i` as sampled on the previous clock. Host writes to that bit have no effect.
- R8: Block-write data bytes beyond the last register are ACKed and discarded.
- R9: A STOP after any complete byte ends the transfer and releases SDA. Bytes already received stay written, and later registers are unchanged.
- R10: While the slave is idle or has not been addressed, `sda_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| fsel_i | input | 1 | Hardware value mirrored into register 0 bit 7 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_o | output | NREG*8 | Register bank, register n in bits 8n+7:8n |

## Verification
The assertions check four properties on every cycle:
- SDA is released whenever the slave is idle.
- A STOP always releases the line.
- The hardware status bit tracks its input.
- Register contents only change on an SCL falling edge.

Only the bench's scenarios can show the protocol-level behaviour. This covers address acceptance and rejection, byte-read data, the count-first order of block reads, the discarding of block-write overruns, and the effect of an early STOP on which registers were written.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            fsel_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG8 = 8'(NREG);
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_RACK = 3'd2, S_TX = 3'd3, S_TACK = 3'd4;
  localparam logic [1:0] P_ADDR = 2'd0, P_CMD = 2'd1, P_CNT = 2'd2, P_DATA = 2'd3;

  function automatic logic [7:0] dflt(int i);
    return (i == 1) ? 8'h85 : (i == 2) ? 8'hFF : 8'h00;
  endfunction

  logic [2:0] scl_q, sda_q;
  logic [2:0] st;
  logic [1:0] ph;
  logic [7:0] sh, tx;
  logic [3:0] bcnt;
  logic [6:0] ptr;
  logic       blk, rd_mode, send_cnt, mnack;
  logic [7:0] regs [NREG];

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire is_idle   = (st == S_IDLE);

  wire [6:0] ptr_inc = (ptr == 7'h7f) ? ptr : ptr + 7'd1;
  wire       in_rng  = {1'b0, ptr} < NREG8;
  wire [7:0] rdval   = in_rng ? regs[ptr[AW-1:0]] : 8'h00;
  wire [7:0] nxt_tx  = send_cnt ? NREG8 : rdval;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111;
      st <= S_IDLE; ph <= P_ADDR; sda_oe <= 1'b0;
      sh <= '0; tx <= '0; bcnt <= '0; ptr <= '0;
      blk <= 1'b0; rd_mode <= 1'b0; send_cnt <= 1'b0; mnack <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
      regs[0][7] <= fsel_i;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (start_det) begin
        st <= S_RX; ph <= P_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              st <= S_RACK; sda_oe <= 1'b1;
              case (ph)
                P_ADDR: begin
                  if (sh[7:1] != DEV_ADDR) begin
                    st <= S_IDLE; sda_oe <= 1'b0;
                  end else begin
                    rd_mode <= sh[0];
                    send_cnt <= blk;
                    if (!sh[0]) ph <= P_CMD;
                  end
                end
                P_CMD: begin
                  blk <= ~sh[7];
                  ptr <= sh[7] ? sh[6:0] : 7'd0;
                  ph  <= sh[7] ? P_DATA : P_CNT;
                end
                P_CNT: ph <= P_DATA;
                default: begin
                  if (in_rng) regs[ptr[AW-1:0]] <= sh;
                  ptr <= ptr_inc;
                end
              endcase
            end
          end
          S_RACK: if (scl_fall) begin
            if (rd_mode) begin
              tx <= nxt_tx; send_cnt <= 1'b0;
              if (!send_cnt) ptr <= ptr_inc;
              st <= S_TX; sda_oe <= ~nxt_tx[7]; bcnt <= '0;
            end else begin
              st <= S_RX; sda_oe <= 1'b0;
            end
          end
          S_TX: if (scl_fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_TACK;
            end else begin
              tx <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              bcnt <= bcnt + 4'd1;
            end
          end
          S_TACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              if (mnack) st <= S_IDLE;
              else begin
                tx <= nxt_tx; send_cnt <= 1'b0;
                if (!send_cnt) ptr <= ptr_inc;
                st <= S_TX; sda_oe <= ~nxt_tx[7]; bcnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
      regs[0][7] <= fsel_i;
    end
  end
endmodule

module smb_cfg_slave_chk #(parameter int NREG = 8) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic fsel_i,
  input logic [NREG*8-1:0] cfg_o,
  input logic idle,
  input logic stop_det,
  input logic scl_fall
);
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_hw_bit_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] == $past(fsel_i));
  assert_write_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o[NREG*8-1:8]) |-> $past(scl_fall));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .fsel_i(fsel_i), .cfg_o(cfg_o),
  .idle(is_idle), .stop_det(stop_det), .scl_fall(scl_fall)
);

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;
  localparam int NREG = 8;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, fsel = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  logic drv_seen;
  logic [7:0] mdl [NREG];

  always #10 clk = ~clk;

  smb_cfg_slave #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .fsel_i(fsel), .sda_oe(sda_oe), .cfg_o(cfg)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bank(string tag);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] e;
      e = mdl[i];
      if (i == 0) e[7] = fsel;
      chk(tag, cfg[i*8 +: 8], e);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; qw; scl = 1'b1; qw; sda_m = 1'b0; qw; scl = 1'b0; qw;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw; scl = 1'b1; qw; sda_m = 1'b1; qw;
  endtask

  task automatic wbit(input logic b);
    sda_m = b; qw; scl = 1'b1; qw;
    if (sda_oe) drv_seen = 1'b1;
    qw; scl = 1'b0; qw;
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qw; scl = 1'b1; qw; b = sda_line; qw; scl = 1'b0; qw;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(last);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d, string tag);
    logic a;
    bus_start;
    wbyte(8'hD2, a); chk({tag, " addr ack R1"}, {7'd0, a}, 8'd1);
    wbyte({1'b1, off}, a); chk({tag, " cmd ack R2"}, {7'd0, a}, 8'd1);
    wbyte(d, a); chk({tag, " data ack R2"}, {7'd0, a}, 8'd1);
    bus_stop;
    if (off < NREG) mdl[off] = d;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte({1'b1, off}, a);
    bus_start;
    wbyte(8'hD3, a); chk("read addr ack R1", {7'd0, a}, 8'd1);
    rbyte(d, 1'b1);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("reset sda_oe R10", {7'd0, sda_oe}, 8'd0);
    chk_bank("reset bank R6");
  endtask

  task automatic t_byte_rw;
    logic [7:0] d;
    byte_write(7'd3, 8'hA5, "bw");
    chk_bank("byte write R2");
    byte_read(7'd3, d);
    chk("byte read R3", d, 8'hA5);
    byte_read(7'd1, d);
    chk("byte read reg1 R3", d, 8'h85);
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start;
    wbyte(8'hA4, a); chk("bad addr nack R1", {7'd0, a}, 8'd0);
    drv_seen = 1'b0;
    wbyte(8'h83, a);
    wbyte(8'h5A, a);
    chk("silent after nack R10", {7'd0, drv_seen}, 8'd0);
    bus_stop;
    chk_bank("bank after bad addr R1");
  endtask

  task automatic t_blk_wr;
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'h00, a);
    wbyte(8'd3, a); chk("count ack R4", {7'd0, a}, 8'd1);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a);
    chk("blk data ack R4", {7'd0, a}, 8'd1);
    bus_stop;
    mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
    chk_bank("block write R4");
  endtask

  task automatic t_hw_bit;
    logic [7:0] d;
    fsel = 1'b0; repeat (4) @(negedge clk);
    chk("hw bit low R7", {7'd0, cfg[7]}, 8'd0);
    byte_write(7'd0, 8'hFF, "hw");
    chk("write ignores bit7 R7", cfg[7:0], 8'h7F);
    byte_read(7'd0, d);
    chk("read reg0 R7", d, 8'h7F);
  endtask

  task automatic t_blk_rd;
    logic a;
    logic [7:0] d;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'h00, a);
    bus_start;
    wbyte(8'hD3, a);
    rbyte(d, 1'b0); chk("block count R5", d, 8'(NREG));
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] e;
      e = mdl[i];
      if (i == 0) e[7] = fsel;
      rbyte(d, (i == NREG - 1));
      chk("block data R5", d, e);
    end
    bus_stop;
  endtask

  task automatic t_overrun;
    logic a;
    int acks = 0;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd10, a);
    for (int i = 0; i < NREG + 2; i++) begin
      wbyte(8'h40 + 8'(i), a);
      if (a) acks++;
      if (i < NREG) mdl[i] = 8'h40 + 8'(i);
    end
    bus_stop;
    chk("overrun acks R8", 8'(acks), 8'(NREG + 2));
    chk_bank("overrun bank R8");
  endtask

  task automatic t_early_stop;
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd4, a);
    wbyte(8'hC1, a); wbyte(8'hC2, a);
    bus_stop;
    chk("released after stop R9", {7'd0, sda_oe}, 8'd0);
    mdl[0] = 8'hC1; mdl[1] = 8'hC2;
    chk_bank("early stop R9");
    byte_write(7'd5, 8'h5E, "after stop");
    chk_bank("next transfer R9");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = (i == 1) ? 8'h85 : (i == 2) ? 8'hFF : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_byte_rw;
    t_bad_addr;
    t_blk_wr;
    t_hw_bit;
    t_blk_rd;
    t_overrun;
    t_early_stop;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule